// File: doc/BRIEF.md
# Skip-Compensating Elastic Buffer

This block carries a stream of 9-bit symbols from a recovered receive clock into a local clock. The two clocks run at nearly the same rate but come from independent sources. A 16-entry dual-clock store sits between them. The buffer aims to stay about half full. It removes or duplicates skip symbols to absorb the rate difference.

Removal happens only in the write domain. A skip that arrives while the store is too full is left in its slot, and the write pointer does not advance, so the next symbol overwrites it. Duplication happens only in the read domain. When the store runs low and the symbol on the output is a skip, the read pointer holds for one local cycle and the same skip is shown twice. No control signal has to cross between the clocks for either action. Only the Gray-coded pointers cross, each through its own synchronizer.

A symbol has a control flag in bit 8 and a value in bits 7:0. The skip symbol is `0x13C`, a control character with value 0x3C. The end-of-packet symbol is a parameter with default `0x1FD`. Each side estimates the fill level from its own pointer and the synchronized pointer of the other side. With two synchronizer stages in steady flow, the write side sees about 12 entries and the read side about 8.

Top module: `eb_elastic`

## Requirements
- R1: After reset, rd_empty is 1, rd_sym is 0x13C, rd_end is 0, wr_full is 0, wr_del is 0 and rd_add is 0. No symbol is delivered until the read side has first seen at least 8 stored entries.
- R2: Each pointer's Gray code changes in at most one bit per clock of its own domain.
- R3: Removal needs a write-side fill of 14 or more, and duplication needs a read-side fill of 6 or fewer. While the fill stays between those limits, every accepted symbol comes out once, in order, including skips. Neither strobe fires.
- R4: wr_full is 1 in the write cycle after the write-side fill reaches 16. A symbol offered while the store is full is dropped and never appears at the output.
- R5: A valid 0x13C arriving while the write-side fill is 14 or more is not kept, and the write pointer holds. wr_del is 1 for exactly the wr_clk cycle after that symbol. Each such incoming skip is removed separately.
- R6: When the read-side fill is 6 or fewer and the valid output is a skip read from the store, the next rd_clk cycle shows the same skip again with rd_add 1. The read pointer holds during that cycle.
- R7: A duplicated skip is not duplicated again. The symbol stored after it follows directly.
- R8: Once delivery has started, it continues at any nonzero fill. When no entry is left, rd_empty is 1 and rd_sym shows the filler 0x13C. Symbols written later are delivered in order.
- R9: rd_end is 1 exactly in the cycles where a valid output equals the end-of-packet symbol (0x1FD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | wr_sym carries a symbol this cycle |
| wr_sym | input | 9 | Incoming symbol: bit 8 control flag, bits 7:0 value |
| wr_full | output | 1 | Store full as seen from the write side |
| wr_del | output | 1 | One-cycle strobe: an incoming skip was removed |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_sym | output | 9 | Outgoing symbol (0x13C filler when empty) |
| rd_empty | output | 1 | rd_sym carries no stored symbol this cycle |
| rd_end | output | 1 | Valid rd_sym is the end-of-packet symbol |
| rd_add | output | 1 | One-cycle strobe: rd_sym is an inserted repeat skip |

## Verification
The write-side results are due one wr_clk edge after the symbol that causes them. wr_del and wr_full are sampled on the falling edge right after that edge. rd_add is due one rd_clk after the first copy of a skip, so the bench checks it together with the second copy in the recorded output stream. When a result depends on synchronizer delay, such as the start of delivery or draining, the bench waits a long settle window. It then compares the whole delivered sequence and its per-symbol flags against the expected list, rather than fixing a cycle number. The fill levels in each scenario are arranged far from the thresholds, so a one-cycle shift in synchronization cannot change the expected result.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int SYM_W = 9;

  typedef enum logic [1:0] {SYM_DATA, SYM_SKIP, SYM_END} sym_kind_e;

  function automatic sym_kind_e classify(input logic [SYM_W-1:0] s,
                                         input logic [SYM_W-1:0] skp,
                                         input logic [SYM_W-1:0] eop);
    if (s == skp)      return SYM_SKIP;
    else if (s == eop) return SYM_END;
    else               return SYM_DATA;
  endfunction
endpackage

// File: rtl/eb_gray_sync.sv
module eb_gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eb_wr_ctrl.sv
module eb_wr_ctrl
  import eb_pkg::*;
#(
  parameter int               AW        = 4,
  parameter int               DEPTH     = 16,
  parameter int               DEL_LEVEL = 14,
  parameter logic [SYM_W-1:0] SKIP_SYM  = 9'h13C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [SYM_W-1:0] in_sym,
  input  logic [AW:0]      rgray_s,
  output logic             we,
  output logic [AW:0]      wbin,
  output logic [AW:0]      wgray,
  output logic             full,
  output logic             del_pulse
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_s, occ, wbin_nxt;
  logic          full_now, del_now;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    occ      = wbin - rbin_s;
    full_now = (occ == PW'(DEPTH));
    del_now  = in_vld && (in_sym == SKIP_SYM) && (occ >= PW'(DEL_LEVEL));
    we       = in_vld && !full_now;
    wbin_nxt = (we && !del_now) ? wbin + 1'b1 : wbin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wgray     <= '0;
      full      <= 1'b0;
      del_pulse <= 1'b0;
    end else begin
      wbin      <= wbin_nxt;
      wgray     <= wbin_nxt ^ (wbin_nxt >> 1);
      full      <= ((wbin_nxt - rbin_s) == PW'(DEPTH));
      del_pulse <= del_now;
    end
  end
endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl #(
  parameter int AW        = 4,
  parameter int HALF      = 8,
  parameter int ADD_LEVEL = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] wgray_s,
  input  logic        cur_skip,
  output logic        load,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray,
  output logic        out_vld,
  output logic        add_pulse
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s, occ, rbin_nxt;
  logic          primed, rep_last, go, rep;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    occ      = wbin_s - rbin;
    go       = primed || (occ >= PW'(HALF));
    rep      = out_vld && cur_skip && !rep_last && (occ <= PW'(ADD_LEVEL));
    load     = go && (occ != '0) && !rep;
    rbin_nxt = load ? rbin + 1'b1 : rbin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin      <= '0;
      rgray     <= '0;
      primed    <= 1'b0;
      out_vld   <= 1'b0;
      add_pulse <= 1'b0;
      rep_last  <= 1'b0;
    end else begin
      rbin      <= rbin_nxt;
      rgray     <= rbin_nxt ^ (rbin_nxt >> 1);
      primed    <= go;
      out_vld   <= load || rep;
      add_pulse <= rep;
      rep_last  <= rep;
    end
  end
endmodule

// File: rtl/eb_elastic.sv
module eb_elastic
  import eb_pkg::*;
#(
  parameter int               DEPTH       = 16,
  parameter int               SYNC_STAGES = 2,
  parameter int               DEL_LEVEL   = 14,
  parameter int               ADD_LEVEL   = 6,
  parameter logic [SYM_W-1:0] SKIP_SYM    = 9'h13C,
  parameter logic [SYM_W-1:0] END_SYM     = 9'h1FD
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_valid,
  input  logic [SYM_W-1:0] wr_sym,
  output logic             wr_full,
  output logic             wr_del,
  input  logic             rd_clk,
  input  logic             rd_rst,
  output logic [SYM_W-1:0] rd_sym,
  output logic             rd_empty,
  output logic             rd_end,
  output logic             rd_add
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;

  logic             we, load, out_vld, cur_skip;
  logic [AW:0]      wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [SYM_W-1:0] mem [DEPTH];
  logic [SYM_W-1:0] rd_q;
  sym_kind_e        kind;

  eb_wr_ctrl #(.AW(AW), .DEPTH(DEPTH), .DEL_LEVEL(DEL_LEVEL), .SKIP_SYM(SKIP_SYM)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .in_vld(wr_valid), .in_sym(wr_sym), .rgray_s(rgray_s),
    .we(we), .wbin(wbin), .wgray(wgray), .full(wr_full), .del_pulse(wr_del)
  );

  eb_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  eb_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  eb_rd_ctrl #(.AW(AW), .HALF(HALF), .ADD_LEVEL(ADD_LEVEL)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .wgray_s(wgray_s), .cur_skip(cur_skip),
    .load(load), .rbin(rbin), .rgray(rgray), .out_vld(out_vld), .add_pulse(rd_add)
  );

  // Storage: one write port in the write domain, one registered read port
  always_ff @(posedge wr_clk) begin
    if (we) mem[wbin[AW-1:0]] <= wr_sym;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)    rd_q <= SKIP_SYM;
    else if (load) rd_q <= mem[rbin[AW-1:0]];
  end

  // Output detect: classify the symbol on the output register
  assign kind     = classify(rd_q, SKIP_SYM, END_SYM);
  assign cur_skip = (kind == SYM_SKIP);
  assign rd_sym   = out_vld ? rd_q : SKIP_SYM;
  assign rd_empty = !out_vld;
  assign rd_end   = out_vld && (kind == SYM_END);
endmodule

// File: rtl/eb_elastic_chk.sv
module eb_elastic_chk #(
  parameter int       PW       = 5,
  parameter int       SW       = 9,
  parameter logic [8:0] SKIP_SYM = 9'h13C
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          wr_valid,
  input logic [SW-1:0] wr_sym,
  input logic          wr_del,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic [SW-1:0] rd_sym,
  input logic          rd_empty,
  input logic          rd_add,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] rgray
);
  a_r2_wgray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $onehot0(wgray ^ $past(wgray)));

  a_r2_rgray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $onehot0(rgray ^ $past(rgray)));

  a_r5_del_from_skip: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_del |-> ($past(wr_valid) && ($past(wr_sym) == SW'(SKIP_SYM))));

  a_r5_del_holds_wptr: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_del |-> $stable(wbin));

  a_r6_add_holds_rptr: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_add |-> ($stable(rbin) && !rd_empty && (rd_sym == SW'(SKIP_SYM))));

  a_r6_add_repeats_prev: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_add |-> ($past(rd_sym) == SW'(SKIP_SYM)));

  a_r7_single_insert: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_add |=> !rd_add);
endmodule

bind eb_elastic eb_elastic_chk #(.PW(AW+1), .SW(eb_pkg::SYM_W), .SKIP_SYM(SKIP_SYM)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_sym(wr_sym),
  .wr_del(wr_del), .wbin(wbin), .wgray(wgray),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_sym(rd_sym), .rd_empty(rd_empty),
  .rd_add(rd_add), .rbin(rbin), .rgray(rgray)
);

// File: tb/eb_elastic_bench.sv
`timescale 1ns/1ps
module eb_elastic_bench;
  localparam logic [8:0] SKP = 9'h13C;
  localparam logic [8:0] EOP = 9'h1FD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rrun = 1'b1;
  logic       rclk;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_sym = '0;
  logic       wr_full, wr_del, rd_empty, rd_end, rd_add;
  logic [8:0] rd_sym;

  int checks = 0;
  int fails  = 0;
  int addc   = 0;
  int delc   = 0;
  int cyc    = 0;

  logic [10:0] got[$];
  logic [8:0]  expq[$];

  always #2.5 clk = ~clk;
  assign rclk = clk & rrun;

  eb_elastic u_eb_elastic (
    .wr_clk(clk), .wr_rst(rst), .wr_valid(wr_valid), .wr_sym(wr_sym),
    .wr_full(wr_full), .wr_del(wr_del),
    .rd_clk(rclk), .rd_rst(rst), .rd_sym(rd_sym), .rd_empty(rd_empty),
    .rd_end(rd_end), .rd_add(rd_add)
  );

  // Output monitor on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rrun && !rd_empty) got.push_back({rd_add, rd_end, rd_sym});
      if (rrun && rd_add) addc++;
      if (wr_del) delc++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmp_stream(input string req);
    check({req, " stream length"}, got.size(), expq.size());
    for (int k = 0; k < got.size() && k < expq.size(); k++) begin
      check({req, " symbol"}, {23'd0, got[k][8:0]}, {23'd0, expq[k]});
      check("R9 end flag", {31'd0, got[k][9]}, {31'd0, expq[k] == EOP});
    end
  endtask

  task automatic do_reset();
    wr_valid = 1'b0;
    rrun = 1'b1;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    got.delete();
    expq.delete();
    addc = 0;
    delc = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic put(input logic [8:0] s);
    wr_valid = 1'b1;
    wr_sym = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    wr_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // R1 and priming
  task automatic t_reset();
    do_reset();
    check("R1 rd_empty", {31'd0, rd_empty}, 32'd1);
    check("R1 rd_sym", {23'd0, rd_sym}, {23'd0, SKP});
    check("R1 rd_end", {31'd0, rd_end}, 32'd0);
    check("R1 wr_full", {31'd0, wr_full}, 32'd0);
    check("R1 wr_del", {31'd0, wr_del}, 32'd0);
    check("R1 rd_add", {31'd0, rd_add}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      put(9'(8'h40 + i));
      expq.push_back(9'(8'h40 + i));
    end
    idle(15);
    check("R1 held below half", got.size(), 32'd0);
    for (int i = 5; i < 10; i++) begin
      put(9'(8'h40 + i));
      expq.push_back(9'(8'h40 + i));
    end
    idle(30);
    cmp_stream("R1 priming");
  endtask

  // R3 in-band pass-through with skips and END
  task automatic t_steady();
    do_reset();
    for (int i = 0; i < 30; i++) begin
      logic [8:0] s;
      if (i < 20 && (i % 6) == 2) s = SKP;
      else if (i == 15)           s = EOP;
      else                        s = {1'b0, 8'(i * 7)};
      put(s);
      expq.push_back(s);
    end
    idle(40);
    cmp_stream("R3 pass-through");
    check("R3 no add", addc, 32'd0);
    check("R3 no delete", delc, 32'd0);
  endtask

  // R5 deletion and R4 full/drop
  task automatic t_delete();
    do_reset();
    rrun = 1'b0;
    for (int i = 0; i < 14; i++) begin
      put(9'(8'h10 + i));
      expq.push_back(9'(8'h10 + i));
    end
    put(SKP);
    check("R5 del strobe first skip", {31'd0, wr_del}, 32'd1);
    check("R4 not full at 14", {31'd0, wr_full}, 32'd0);
    put(SKP);
    check("R5 del strobe second skip", {31'd0, wr_del}, 32'd1);
    put(9'h01E);
    expq.push_back(9'h01E);
    check("R5 del strobe one cycle", {31'd0, wr_del}, 32'd0);
    put(9'h01F);
    expq.push_back(9'h01F);
    check("R4 full at 16", {31'd0, wr_full}, 32'd1);
    put(9'h0AA);
    check("R4 still full", {31'd0, wr_full}, 32'd1);
    check("R4 no del on data", {31'd0, wr_del}, 32'd0);
    idle(2);
    check("R5 delete count", delc, 32'd2);
    rrun = 1'b1;
    idle(40);
    cmp_stream("R4 R5 drain");
    check("R4 not full after drain", {31'd0, wr_full}, 32'd0);
  endtask

  // R6 insertion, R7 single repeat, R8 empty and resume
  task automatic t_add();
    do_reset();
    for (int i = 0; i < 10; i++) begin
      put(9'(8'h60 + i));
      expq.push_back(9'(8'h60 + i));
    end
    put(SKP);
    expq.push_back(SKP);
    expq.push_back(SKP);
    put(9'h06A); expq.push_back(9'h06A);
    put(9'h06B); expq.push_back(9'h06B);
    idle(40);
    cmp_stream("R6 R7 insert");
    check("R7 one insertion", addc, 32'd1);
    if (got.size() > 11) begin
      check("R6 add on second copy", {31'd0, got[11][10]}, 32'd1);
      check("R6 no add on first copy", {31'd0, got[10][10]}, 32'd0);
    end else begin
      check("R6 stream too short", got.size(), 32'd12);
    end
    check("R8 empty", {31'd0, rd_empty}, 32'd1);
    check("R8 filler", {23'd0, rd_sym}, {23'd0, SKP});
    for (int i = 0; i < 3; i++) begin
      put(9'(8'h70 + i));
      expq.push_back(9'(8'h70 + i));
    end
    idle(20);
    cmp_stream("R8 resume");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected under 50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_steady();
    t_delete();
    t_add();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule